// File: doc/BRIEF.md
# Synchronising Register File with Thread Suspension

This block is a register file for a multithreaded core in which every entry can serve as an ordinary register or as a write-once synchronisation cell. Each cell carries a dataflow state of empty, waiting or full. A pipeline read that finds a source operand not full does not return data. Instead it parks the reading thread on that cell. A later write fills the cell and hands every parked thread back to the scheduler, one thread per cycle.

The pipeline has two read ports, which act as one operand pair, and one write port. The write port can also perform an "arm" operation for long-latency results: this marks the target cell empty, so that dependent reads suspend until the real value arrives. Auxiliary agents share one extra read port and one extra write port, each through a round-robin arbiter. Parked threads are kept in a per-thread next-pointer table. Each waiting cell keeps the head and tail of its own list. On a fill, that list is spliced onto one global wake queue, which drains at one thread per cycle.

Top module: `sync_regfile`

## Requirements
- R1: After reset every cell is full and holds 0, `wake_vld` is 0, and no grant is raised without a request.
- R2: A pipeline read (`rd_vld`=1) whose two operands are both full sets `rd_ok`=1 in the same cycle, returns both values, and leaves the cells unchanged.
- R3: A pipeline read with an operand that is not full sets `rd_ok`=0 and `rd_susp`=1 in the same cycle. The thread `rd_tid` is parked on operand A if A is not full, and otherwise on operand B. That cell then becomes waiting.
- R4: A non-arming write in the same cycle, from the pipeline or a granted auxiliary writer, to an operand's address makes that operand count as full, and its data is the written value.
- R5: A non-arming write to a waiting cell stores the value and makes the cell full. Every thread parked on it then appears on `wake_tid` with `wake_vld`=1, one per cycle, in the order the threads were parked. The first one appears in the cycle after the write.
- R6: A pipeline write with `wr_async`=1 turns a full cell empty and keeps its data. A waiting or empty cell keeps its state.
- R7: A non-arming write to a full cell overwrites the data, and `ovw_err` is 1 in that same cycle. A write to an empty cell fills it with `ovw_err`=0.
- R8: The auxiliary read port grants one requester per cycle in round-robin order: after a grant to requester i, priority starts at i+1, and requester 0 has priority after reset. The granted requester sees the cell's current data and a full flag on `aux_rd_full` (1 means full). The read never parks anything and changes no state.
- R9: The auxiliary write port grants a requester only in cycles with `wr_vld`=0, in the same round-robin order. A requester that is not granted keeps its request until it is granted.
- R10: When several waiting cells are filled in successive cycles, their threads leave the wake queue in the order of the fills, and within each cell in the order the threads were parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_vld | input | 1 | Pipeline operand read valid |
| rd_tid | input | TW | Thread issuing the read |
| rd_a_addr | input | AW | Operand A cell |
| rd_b_addr | input | AW | Operand B cell |
| rd_ok | output | 1 | Both operands full; the instruction may issue |
| rd_susp | output | 1 | The reading thread is parked |
| rd_a_data | output | DW | Operand A value |
| rd_b_data | output | DW | Operand B value |
| wr_vld | input | 1 | Pipeline write valid |
| wr_async | input | 1 | Arm the cell (mark it empty) instead of writing data |
| wr_addr | input | AW | Pipeline write cell |
| wr_data | input | DW | Pipeline write value |
| ovw_err | output | 1 | A fill hit a full cell |
| aux_rd_req | input | NAUX | Auxiliary read requests |
| aux_rd_addr | input | NAUX*AW | Auxiliary read cells, packed by requester |
| aux_rd_gnt | output | NAUX | Auxiliary read grant, one-hot or zero |
| aux_rd_data | output | DW | Granted auxiliary read value |
| aux_rd_full | output | 1 | Granted cell is full |
| aux_wr_req | input | NAUX | Auxiliary write requests |
| aux_wr_addr | input | NAUX*AW | Auxiliary write cells, packed |
| aux_wr_data | input | NAUX*DW | Auxiliary write values, packed |
| aux_wr_gnt | output | NAUX | Auxiliary write grant, one-hot or zero |
| wake_vld | output | 1 | A released thread is presented |
| wake_tid | output | TW | Released thread index |

## Verification
The read verdict, operand data, overwrite flag and both grants are combinational, so they are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and compares these outputs 3 ns later, before the rising edge that commits them. Cell state and the wake queue change at that rising edge. A thread released by a fill is therefore expected on `wake_tid` from the next cycle on, one queue entry per cycle. The bench model pops its own wake queue once per edge and checks the queue head in each sampling window. Directed sequences cover parking order across the A/B operands, arming of full and waiting cells, same-cycle bypass, overwrite and back-to-back fills. These are followed by seeded random traffic with held auxiliary requests.

// File: rtl/srf_pkg.sv
package srf_pkg;
  typedef enum logic [1:0] {
    CS_EMPTY = 2'd0,
    CS_WAIT  = 2'd1,
    CS_FULL  = 2'd2
  } cell_st_t;

  // next index in round-robin order, wrapping at n
  function automatic int rr_wrap(input int base, input int step, input int n);
    return (base + step) % n;
  endfunction
endpackage

// File: rtl/srf_rr_arb.sv
module srf_rr_arb #(
  parameter int N  = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  logic [IW-1:0] last_q;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int k = 1; k <= N; k++) begin
      if (en && !gnt_any && req[srf_pkg::rr_wrap(int'(last_q), k, N)]) begin
        gnt[srf_pkg::rr_wrap(int'(last_q), k, N)] = 1'b1;
        gnt_idx = IW'(srf_pkg::rr_wrap(int'(last_q), k, N));
        gnt_any = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       last_q <= IW'(N - 1);
    else if (gnt_any) last_q <= gnt_idx;
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R8
  AST_GNT_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_any && $countones(req) > 1) |=> !(gnt_any && gnt_idx == $past(gnt_idx) && $countones(req) > 1)); // R9
endmodule

// File: rtl/srf_link_tab.sv
module srf_link_tab #(
  parameter int NTHR = 8,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_a,
  input  logic [TW-1:0] wa_a,
  input  logic [TW-1:0] wd_a,
  input  logic          we_b,
  input  logic [TW-1:0] wa_b,
  input  logic [TW-1:0] wd_b,
  input  logic [TW-1:0] ra,
  output logic [TW-1:0] rd
);
  logic [TW-1:0] nxt [NTHR];

  assign rd = nxt[ra];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTHR; i++) nxt[i] <= '0;
    end else begin
      if (we_a) nxt[wa_a] <= wd_a;
      if (we_b) nxt[wa_b] <= wd_b;
    end
  end

  AST_LINK_PORTS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    (we_a && we_b) |-> (wa_a != wa_b)); // R10
endmodule

// File: rtl/srf_wake_q.sv
module srf_wake_q #(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seg_en,
  input  logic [TW-1:0] seg_head,
  input  logic [TW-1:0] seg_tail,
  input  logic [TW-1:0] link_rd,
  output logic [TW-1:0] link_ra,
  output logic          lk_we,
  output logic [TW-1:0] lk_wa,
  output logic [TW-1:0] lk_wd,
  output logic          wake_vld,
  output logic [TW-1:0] wake_tid
);
  logic          ne_q, n_ne;
  logic [TW-1:0] head_q, tail_q, n_head, n_tail;
  logic          rem_ne;

  assign wake_vld = ne_q;
  assign wake_tid = head_q;
  assign link_ra  = head_q;
  // after the pop of the head, something remains only if head and tail differ
  assign rem_ne   = ne_q && (head_q != tail_q);

  always_comb begin
    lk_we  = 1'b0;
    lk_wa  = tail_q;
    lk_wd  = seg_head;
    n_ne   = rem_ne;
    n_head = link_rd;
    n_tail = tail_q;
    if (seg_en) begin
      n_ne   = 1'b1;
      n_tail = seg_tail;
      if (rem_ne) begin
        lk_we = 1'b1;
      end else begin
        n_head = seg_head;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ne_q   <= 1'b0;
      head_q <= '0;
      tail_q <= '0;
    end else begin
      ne_q   <= n_ne;
      head_q <= n_head;
      tail_q <= n_tail;
    end
  end

  AST_WAKE_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_vld && head_q != tail_q) |=> wake_vld); // R5
  AST_SPLICE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    seg_en |=> (wake_vld && tail_q == $past(seg_tail))); // R10
endmodule

// File: rtl/sync_regfile.sv
module sync_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int NTHR = 8,
  parameter int NAUX = 2,
  localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int TW  = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int XW  = (NAUX > 1) ? $clog2(NAUX) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_vld,
  input  logic [TW-1:0]      rd_tid,
  input  logic [AW-1:0]      rd_a_addr,
  input  logic [AW-1:0]      rd_b_addr,
  output logic               rd_ok,
  output logic               rd_susp,
  output logic [DW-1:0]      rd_a_data,
  output logic [DW-1:0]      rd_b_data,
  input  logic               wr_vld,
  input  logic               wr_async,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  output logic               ovw_err,
  input  logic [NAUX-1:0]    aux_rd_req,
  input  logic [NAUX*AW-1:0] aux_rd_addr,
  output logic [NAUX-1:0]    aux_rd_gnt,
  output logic [DW-1:0]      aux_rd_data,
  output logic               aux_rd_full,
  input  logic [NAUX-1:0]    aux_wr_req,
  input  logic [NAUX*AW-1:0] aux_wr_addr,
  input  logic [NAUX*DW-1:0] aux_wr_data,
  output logic [NAUX-1:0]    aux_wr_gnt,
  output logic               wake_vld,
  output logic [TW-1:0]      wake_tid
);
  import srf_pkg::*;

  cell_st_t      c_st   [NREG];
  logic [DW-1:0] c_data [NREG];
  logic [TW-1:0] c_head [NREG];
  logic [TW-1:0] c_tail [NREG];

  // merged write port: pipeline first, auxiliary only when pipeline is idle
  logic [XW-1:0] wg_idx, rg_idx;
  logic          wg_any, rg_any;
  logic          w_en, w_async, w_fill;
  logic [AW-1:0] w_addr, ar_addr, sus_addr;
  logic [DW-1:0] w_data;
  logic          a_full, b_full, seg_en;
  logic          lk_we;
  logic [TW-1:0] lk_wa, lk_wd, link_ra, link_rd;

  srf_rr_arb #(.N(NAUX)) u_wr_arb (
    .clk(clk), .rst_n(rst_n), .en(!wr_vld), .req(aux_wr_req),
    .gnt(aux_wr_gnt), .gnt_idx(wg_idx), .gnt_any(wg_any)
  );

  srf_rr_arb #(.N(NAUX)) u_rd_arb (
    .clk(clk), .rst_n(rst_n), .en(1'b1), .req(aux_rd_req),
    .gnt(aux_rd_gnt), .gnt_idx(rg_idx), .gnt_any(rg_any)
  );

  assign w_en    = wr_vld || wg_any;
  assign w_async = wr_vld && wr_async;
  assign w_fill  = w_en && !w_async;
  assign w_addr  = wr_vld ? wr_addr : aux_wr_addr[wg_idx*AW +: AW];
  assign w_data  = wr_vld ? wr_data : aux_wr_data[wg_idx*DW +: DW];

  // operand is usable if full, or filled by this cycle's write (bypass)
  function automatic logic op_ready(input cell_st_t st, input logic [AW-1:0] a);
    return (st == CS_FULL) || (w_fill && (w_addr == a));
  endfunction

  function automatic logic [DW-1:0] op_value(input logic [DW-1:0] d, input logic [AW-1:0] a);
    return (w_fill && (w_addr == a)) ? w_data : d;
  endfunction

  assign a_full    = op_ready(c_st[rd_a_addr], rd_a_addr);
  assign b_full    = op_ready(c_st[rd_b_addr], rd_b_addr);
  assign rd_ok     = rd_vld && a_full && b_full;
  assign rd_susp   = rd_vld && !(a_full && b_full);
  assign sus_addr  = a_full ? rd_b_addr : rd_a_addr;
  assign rd_a_data = op_value(c_data[rd_a_addr], rd_a_addr);
  assign rd_b_data = op_value(c_data[rd_b_addr], rd_b_addr);

  assign ovw_err   = w_fill && (c_st[w_addr] == CS_FULL);
  assign seg_en    = w_fill && (c_st[w_addr] == CS_WAIT);

  assign ar_addr     = aux_rd_addr[rg_idx*AW +: AW];
  assign aux_rd_data = rg_any ? c_data[ar_addr] : '0;
  assign aux_rd_full = rg_any && (c_st[ar_addr] == CS_FULL);

  srf_link_tab #(.NTHR(NTHR)) u_links (
    .clk(clk), .rst_n(rst_n),
    .we_a(rd_susp && c_st[sus_addr] == CS_WAIT), .wa_a(c_tail[sus_addr]), .wd_a(rd_tid),
    .we_b(lk_we), .wa_b(lk_wa), .wd_b(lk_wd),
    .ra(link_ra), .rd(link_rd)
  );

  srf_wake_q #(.TW(TW)) u_wake (
    .clk(clk), .rst_n(rst_n), .seg_en(seg_en),
    .seg_head(c_head[w_addr]), .seg_tail(c_tail[w_addr]),
    .link_rd(link_rd), .link_ra(link_ra),
    .lk_we(lk_we), .lk_wa(lk_wa), .lk_wd(lk_wd),
    .wake_vld(wake_vld), .wake_tid(wake_tid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        c_st[i]   <= CS_FULL;
        c_data[i] <= '0;
        c_head[i] <= '0;
        c_tail[i] <= '0;
      end
    end else begin
      if (w_en) begin
        if (w_async) begin
          if (c_st[w_addr] == CS_FULL) c_st[w_addr] <= CS_EMPTY;
        end else begin
          c_st[w_addr]   <= CS_FULL;
          c_data[w_addr] <= w_data;
        end
      end
      // a parking read never targets a cell being filled (bypass makes it full)
      if (rd_susp) begin
        c_tail[sus_addr] <= rd_tid;
        if (c_st[sus_addr] == CS_EMPTY) begin
          c_st[sus_addr]   <= CS_WAIT;
          c_head[sus_addr] <= rd_tid;
        end
      end
    end
  end

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |-> (aux_wr_gnt == '0)); // R9
  AST_PARK_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_susp |=> (c_st[$past(sus_addr)] == CS_WAIT)); // R3
  AST_FILL_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    seg_en |=> wake_vld); // R5
  AST_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ovw_err |=> (c_st[$past(w_addr)] == CS_FULL && c_data[$past(w_addr)] == $past(w_data))); // R7
  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && !w_en) |=> (c_st[$past(rd_a_addr)] == CS_FULL)); // R2
endmodule

// File: tb/tb_sync_regfile.sv
module tb_sync_regfile;
  localparam int NREG = 8, DW = 16, NTHR = 8, NAUX = 2;
  localparam int AW = 3, TW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic rd_vld = 0, rd_ok, rd_susp, wr_vld = 0, wr_async = 0, ovw_err, aux_rd_full, wake_vld;
  logic [TW-1:0] rd_tid = 0, wake_tid;
  logic [AW-1:0] rd_a_addr = 0, rd_b_addr = 0, wr_addr = 0;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data = 0, aux_rd_data;
  logic [NAUX-1:0] aux_rd_req = 0, aux_wr_req = 0, aux_rd_gnt, aux_wr_gnt;
  logic [AW-1:0] ra [NAUX], wa [NAUX];
  logic [DW-1:0] wd [NAUX];
  logic [NAUX*AW-1:0] aux_rd_addr, aux_wr_addr;
  logic [NAUX*DW-1:0] aux_wr_data;

  always_comb begin
    for (int i = 0; i < NAUX; i++) begin
      aux_rd_addr[i*AW +: AW] = ra[i];
      aux_wr_addr[i*AW +: AW] = wa[i];
      aux_wr_data[i*DW +: DW] = wd[i];
    end
  end

  sync_regfile #(.NREG(NREG), .DW(DW), .NTHR(NTHR), .NAUX(NAUX)) dut (
    .clk(clk), .rst_n(rst_n), .rd_vld(rd_vld), .rd_tid(rd_tid),
    .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr), .rd_ok(rd_ok), .rd_susp(rd_susp),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .wr_vld(wr_vld), .wr_async(wr_async),
    .wr_addr(wr_addr), .wr_data(wr_data), .ovw_err(ovw_err),
    .aux_rd_req(aux_rd_req), .aux_rd_addr(aux_rd_addr), .aux_rd_gnt(aux_rd_gnt),
    .aux_rd_data(aux_rd_data), .aux_rd_full(aux_rd_full),
    .aux_wr_req(aux_wr_req), .aux_wr_addr(aux_wr_addr), .aux_wr_data(aux_wr_data),
    .aux_wr_gnt(aux_wr_gnt), .wake_vld(wake_vld), .wake_tid(wake_tid)
  );

  // bench model: 0 empty, 1 waiting, 2 full
  int m_st [NREG];
  int m_dat [NREG];
  int cq [NREG][$];
  int wq [$];
  bit busy [NTHR];
  int lr, lw;
  int checks = 0, errors = 0;
  string dtag = "";
  int drop_r = -1, drop_w = -1;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    string t;
    t = (dtag != "") ? dtag : tag;
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
    end
  endtask

  function automatic int rr_pick(input logic [NAUX-1:0] req, input int last);
    for (int k = 1; k <= NAUX; k++) begin
      if (req[(last + k) % NAUX]) return (last + k) % NAUX;
    end
    return -1;
  endfunction

  task automatic idle_inputs();
    rd_vld = 0; wr_vld = 0; wr_async = 0;
  endtask

  // called just after a falling edge with inputs set
  task automatic run_cycle();
    int wg, rg, wad, wdt, s;
    bit wen, wfill, fa, fb, ok;
    #3;
    wg = wr_vld ? -1 : rr_pick(aux_wr_req, lw);
    wen = wr_vld || (wg >= 0);
    wfill = wen && !(wr_vld && wr_async);
    wad = wr_vld ? int'(wr_addr) : (wg >= 0 ? int'(wa[wg]) : 0);
    wdt = wr_vld ? int'(wr_data) : (wg >= 0 ? int'(wd[wg]) : 0);
    fa = (m_st[rd_a_addr] == 2) || (wfill && wad == int'(rd_a_addr));
    fb = (m_st[rd_b_addr] == 2) || (wfill && wad == int'(rd_b_addr));
    ok = rd_vld && fa && fb;
    chk(ok ? "R2" : "R3", "rd_ok", int'(rd_ok), int'(ok));
    chk("R3", "rd_susp", int'(rd_susp), int'(rd_vld && !ok));
    if (ok) begin
      chk((wfill && wad == int'(rd_a_addr)) ? "R4" : "R2", "rd_a_data", int'(rd_a_data),
          (wfill && wad == int'(rd_a_addr)) ? wdt : m_dat[rd_a_addr]);
      chk((wfill && wad == int'(rd_b_addr)) ? "R4" : "R2", "rd_b_data", int'(rd_b_data),
          (wfill && wad == int'(rd_b_addr)) ? wdt : m_dat[rd_b_addr]);
    end
    chk("R7", "ovw_err", int'(ovw_err), int'(wfill && m_st[wad] == 2));
    rg = rr_pick(aux_rd_req, lr);
    chk("R8", "aux_rd_gnt", int'(aux_rd_gnt), rg >= 0 ? (1 << rg) : 0);
    if (rg >= 0) begin
      chk("R8", "aux_rd_data", int'(aux_rd_data), m_dat[ra[rg]]);
      chk("R8", "aux_rd_full", int'(aux_rd_full), int'(m_st[ra[rg]] == 2));
    end
    chk("R9", "aux_wr_gnt", int'(aux_wr_gnt), wg >= 0 ? (1 << wg) : 0);
    chk("R5", "wake_vld", int'(wake_vld), int'(wq.size() > 0));
    if (wq.size() > 0) chk("R5", "wake_tid", int'(wake_tid), wq[0]);
    @(posedge clk);
    if (wq.size() > 0) begin busy[wq[0]] = 0; void'(wq.pop_front()); end
    if (wen) begin
      if (wr_vld && wr_async) begin
        if (m_st[wad] == 2) m_st[wad] = 0;
      end else begin
        if (m_st[wad] == 1) begin
          foreach (cq[wad][i]) wq.push_back(cq[wad][i]);
          cq[wad].delete();
        end
        m_st[wad] = 2;
        m_dat[wad] = wdt;
      end
    end
    if (rd_vld && !ok) begin
      s = fa ? int'(rd_b_addr) : int'(rd_a_addr);
      if (m_st[s] == 0) m_st[s] = 1;
      cq[s].push_back(int'(rd_tid));
      busy[rd_tid] = 1;
    end
    if (rg >= 0) begin lr = rg; drop_r = rg; end
    if (wg >= 0) begin lw = wg; drop_w = wg; end
    @(negedge clk);
    if (drop_r >= 0) aux_rd_req[drop_r] = 0;
    if (drop_w >= 0) aux_wr_req[drop_w] = 0;
    drop_r = -1; drop_w = -1;
  endtask

  task automatic pread(input int tid, input int a, input int b);
    rd_vld = 1; rd_tid = TW'(tid); rd_a_addr = AW'(a); rd_b_addr = AW'(b);
  endtask

  task automatic pwrite(input int a, input int d, input bit arm);
    wr_vld = 1; wr_addr = AW'(a); wr_data = DW'(d); wr_async = arm;
  endtask

  initial begin
    int seed, tid;
    for (int i = 0; i < NREG; i++) begin m_st[i] = 2; m_dat[i] = 0; end
    for (int i = 0; i < NTHR; i++) busy[i] = 0;
    for (int i = 0; i < NAUX; i++) begin ra[i] = 0; wa[i] = 0; wd[i] = 0; end
    lr = NAUX - 1; lw = NAUX - 1;
    seed = $urandom(32'h5eed_1234);
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    #3;
    chk("R1", "wake_vld after reset", int'(wake_vld), 0);
    chk("R1", "grants after reset", int'({aux_rd_gnt, aux_wr_gnt}), 0);
    @(negedge clk);
    // R1: cells reset full with 0, read via both operands
    dtag = "R1"; idle_inputs(); pread(0, 3, 5); run_cycle(); dtag = "";
    // R6: arm full cell 2, it becomes empty
    idle_inputs(); pwrite(2, 0, 1); run_cycle();
    // R3: thread 1 parks on A (cell 2)
    idle_inputs(); pread(1, 2, 0); run_cycle();
    // R3: A full, B empty -> parks on B
    idle_inputs(); pread(2, 0, 2); run_cycle();
    idle_inputs(); pread(3, 2, 2); run_cycle();
    // R6: arming a waiting cell keeps it waiting; aux read shows not full
    dtag = "R6"; idle_inputs(); pwrite(2, 0, 1); run_cycle();
    idle_inputs(); aux_rd_req[0] = 1; ra[0] = 2; run_cycle(); dtag = "";
    idle_inputs(); pwrite(4, 0, 1); run_cycle();
    idle_inputs(); pread(4, 4, 4); run_cycle();
    // R10: two fills back to back, wake order 1,2,3 then 4
    dtag = "R10"; idle_inputs(); pwrite(2, 16'h1234, 0); run_cycle();
    idle_inputs(); pwrite(4, 16'h0055, 0); run_cycle();
    // R7: overwrite a full cell
    idle_inputs(); pwrite(2, 16'h4321, 0); run_cycle(); dtag = "";
    // R4: bypass of same-cycle fill into empty cell 6
    idle_inputs(); pwrite(6, 0, 1); run_cycle();
    dtag = "R4"; idle_inputs(); pread(5, 6, 6); pwrite(6, 16'h0077, 0); run_cycle(); dtag = "";
    // R9: aux writers held while pipeline writes, then rotate
    idle_inputs(); aux_wr_req = 2'b11; wa[0] = 1; wd[0] = 16'h0a0a; wa[1] = 7; wd[1] = 16'h0b0b;
    pwrite(0, 16'h0001, 0); run_cycle();
    idle_inputs(); run_cycle(); run_cycle(); run_cycle();
    // R8: both aux readers contend
    aux_rd_req = 2'b11; ra[0] = 7; ra[1] = 1; run_cycle(); run_cycle(); run_cycle();
    // random traffic
    for (int cyc = 0; cyc < 4000; cyc++) begin
      idle_inputs();
      if ($urandom_range(99) < 60) begin
        tid = -1;
        for (int t = 0; t < NTHR; t++) begin
          int c;
          c = (t + int'($urandom_range(NTHR - 1))) % NTHR;
          if (tid < 0 && !busy[c]) tid = c;
        end
        if (tid >= 0) pread(tid, $urandom_range(NREG - 1), $urandom_range(NREG - 1));
      end
      if ($urandom_range(99) < 40)
        pwrite($urandom_range(NREG - 1), $urandom_range(16'hffff), $urandom_range(99) < 25);
      for (int i = 0; i < NAUX; i++) begin
        if (!aux_rd_req[i] && $urandom_range(99) < 30) begin
          aux_rd_req[i] = 1; ra[i] = AW'($urandom_range(NREG - 1));
        end
        if (!aux_wr_req[i] && $urandom_range(99) < 15) begin
          aux_wr_req[i] = 1; wa[i] = AW'($urandom_range(NREG - 1)); wd[i] = DW'($urandom_range(16'hffff));
        end
      end
      run_cycle();
    end
    idle_inputs(); aux_rd_req = 0; aux_wr_req = 0;
    dtag = "R5";
    repeat (NTHR + 4) run_cycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule